// File: doc/BRIEF.md
# Single-Wire LED Pixel Stream Encoder

This block serialises a frame of pixel colour data onto one self-clocked output line that drives a chain of addressable LEDs. Each bit occupies a fixed period of three phases. The line goes to its active level when the bit starts. It returns to idle after the first phase for a zero and after the second phase for a one. It then stays idle until the bit period ends. A frame starts with a start pulse that carries a pixel count. Pixel bytes arrive on a valid/ready byte port, or one latched colour is repeated for the whole frame.

Every colour byte is multiplied by a global 8-bit brightness value, and the three channels of each pixel are sent in a configurable order. The line polarity can be inverted. Pixel data is collected while the current pixel is still being sent, so bits leave with no gap between bytes or pixels. If the next pixel is not ready when the current one ends, the frame is cut short and an error flag is raised. After every frame the line is held idle for a minimum time so the LEDs latch. The block stays busy until that time has passed and then pulses done.

Top module: `led_wave_encoder`

## Requirements
- R1: Every bit lasts T1_CYC+T2_CYC+T3_CYC cycles. The line is at the active level for the first T1_CYC cycles of a 0 bit, or for the first T1_CYC+T2_CYC cycles of a 1 bit, and is idle for the rest of the period.
- R2: Each pixel sends 24 bits, most-significant bit of each colour byte first. Bytes and pixels follow one another with no idle period between bit periods.
- R3: Input channel order is first byte = red, second = green, third = blue. cfg_order, latched at start, picks the transmit order: 0 RGB, 1 RBG, 2 GRB, 3 GBR, 4 BRG, 5 BGR, and 6 or 7 send RGB.
- R4: Each transmitted colour byte equals (byte × cfg_scale) >> 8, with cfg_scale latched at start. A scale of 0 sends only 0 bits.
- R5: The idle level equals cfg_invert and the active level is its complement. While busy is low the line is at the idle level.
- R6: After the last bit period of a frame, the line stays idle and busy stays high for exactly GAP_CYC cycles. busy then falls, and done is high for that one cycle only.
- R7: With cfg_four_byte set at start, the first byte of every four accepted input bytes is dropped and the next three form the pixel.
- R8: With cfg_solid set at start, in_ready stays low for the whole frame and every pixel transmits solid_color (red [23:16], green [15:8], blue [7:0]).
- R9: If the next pixel is incomplete when the current pixel's last bit period ends, the frame stops, the line stays idle, underrun goes high and holds until the next accepted start, and the trailing gap and done of R6 still follow.
- R10: After reset, busy, done, in_ready and underrun are low and the line is at the idle level.
- R11: A start while busy is ignored. A start with pixel_count 0 sends no bit, keeps busy high and the line idle for GAP_CYC+1 cycles, and then pulses done.
- R12: Between an accepted start and the first bit, the line is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only while not busy) |
| pixel_count | input | CNT_W | Number of pixels in the frame |
| cfg_order | input | 3 | Transmit channel order code |
| cfg_scale | input | 8 | Brightness multiplier |
| cfg_invert | input | 1 | Swap active and idle line levels |
| cfg_four_byte | input | 1 | Input pixels carry a leading byte to drop |
| cfg_solid | input | 1 | Repeat solid_color instead of reading input |
| solid_color | input | 24 | Colour used in solid mode |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| led_out | output | 1 | Serial line to the LED chain |
| busy | output | 1 | Frame in progress, trailing gap included |
| done | output | 1 | One-cycle pulse when a frame completes |
| underrun | output | 1 | Frame cut short for lack of data |

## Verification
A corrupted shift register or channel select changes which bits come out, and the per-cycle waveform comparison reports it at the first bit period that differs. A phase counter that is off by one moves a falling edge, and this shows at the very first bit of the frame. An error in the pixel or fetch counters makes a frame too short or too long, or raises a false underrun. That shows when the bit stream ends, before the trailing gap would complete. A gap counter error shows as a wrong number of idle busy cycles before done.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    localparam int CH_W   = 8;
    localparam int NUM_CH = 3;
    localparam int PX_W   = CH_W * NUM_CH;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2,
        ST_GAP  = 2'd3
    } enc_state_t;

    // Channel a = first input byte (red), b = green, c = blue.
    function automatic logic [PX_W-1:0] arrange(input logic [2:0] ord,
                                                input logic [CH_W-1:0] a,
                                                input logic [CH_W-1:0] b,
                                                input logic [CH_W-1:0] c);
        logic [PX_W-1:0] w;
        case (ord)
            3'd1:    w = {a, c, b};
            3'd2:    w = {b, a, c};
            3'd3:    w = {b, c, a};
            3'd4:    w = {c, a, b};
            3'd5:    w = {c, b, a};
            default: w = {a, b, c};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/led_chan_scale.sv
module led_chan_scale #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] scale,
    output logic [W-1:0] res
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = val * scale;
        res  = prod[2*W-1:W];
    end
endmodule

// File: rtl/led_pixel_stage.sv
module led_pixel_stage
    import led_enc_pkg::*;
#(
    parameter int BYTE_W = CH_W,
    parameter int CHANS  = NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    enable,
    input  logic                    four_byte,
    input  logic                    take,
    input  logic                    in_valid,
    input  logic [BYTE_W-1:0]       in_data,
    output logic                    in_ready,
    output logic                    full,
    output logic [BYTE_W*CHANS-1:0] pixel,
    output logic                    got
);
    localparam int STG_W = BYTE_W * CHANS;
    localparam int IW    = $clog2(CHANS + 1);

    typedef struct packed {
        logic [IW-1:0]    idx;
        logic             full;
        logic [STG_W-1:0] px;
    } stage_t;

    stage_t q, d;
    logic [IW-1:0] last_idx;

    always_comb begin
        last_idx = four_byte ? IW'(CHANS) : IW'(CHANS - 1);
        in_ready = enable && !q.full;
        d        = q;
        got      = 1'b0;
        if (clear) begin
            d.idx  = '0;
            d.full = 1'b0;
        end else begin
            if (take) begin
                d.full = 1'b0;
            end
            if (in_valid && in_ready) begin
                if (four_byte && (q.idx == '0)) begin
                    d.idx = IW'(1);
                end else begin
                    d.px = {q.px[STG_W-BYTE_W-1:0], in_data};
                    if (q.idx == last_idx) begin
                        d.idx  = '0;
                        d.full = 1'b1;
                        got    = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full  = q.full;
    assign pixel = q.px;
endmodule

// File: rtl/led_bit_serial.sv
module led_bit_serial #(
    parameter int WORD_W = 24,
    parameter int T1     = 50,
    parameter int T2     = 50,
    parameter int T3     = 56,
    localparam int TBIT  = T1 + T2 + T3,
    localparam int PH_W  = $clog2(TBIT),
    localparam int BI_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              run,
    output logic              active,
    output logic              word_end,
    output logic [PH_W-1:0]   phase
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [PH_W-1:0]   ph;
        logic [BI_W-1:0]   bi;
        logic              act;
    } ser_t;

    ser_t q, d;
    logic last_ph;

    always_comb begin
        d        = q;
        last_ph  = (q.ph == PH_W'(TBIT - 1));
        word_end = run && last_ph && (q.bi == BI_W'(WORD_W - 1));
        d.act    = run && ((q.ph < PH_W'(T1)) ||
                           ((q.ph < PH_W'(T1 + T2)) && q.sh[WORD_W-1]));
        if (load) begin
            d.sh = word;
            d.ph = '0;
            d.bi = '0;
        end else if (run) begin
            if (last_ph) begin
                d.ph = '0;
                d.bi = q.bi + 1'b1;
                d.sh = {q.sh[WORD_W-2:0], 1'b0};
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end else begin
            d.ph = '0;
            d.bi = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = q.act;
    assign phase  = q.ph;
endmodule

// File: rtl/led_wave_encoder.sv
module led_wave_encoder
    import led_enc_pkg::*;
#(
    parameter int T1_CYC  = 50,
    parameter int T2_CYC  = 50,
    parameter int T3_CYC  = 56,
    parameter int GAP_CYC = 6250,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] pixel_count,
    input  logic [2:0]       cfg_order,
    input  logic [7:0]       cfg_scale,
    input  logic             cfg_invert,
    input  logic             cfg_four_byte,
    input  logic             cfg_solid,
    input  logic [23:0]      solid_color,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             led_out,
    output logic             busy,
    output logic             done,
    output logic             underrun
);
    localparam int TBIT  = T1_CYC + T2_CYC + T3_CYC;
    localparam int PH_W  = $clog2(TBIT);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    typedef struct packed {
        enc_state_t       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] sent;
        logic [CNT_W-1:0] fetched;
        logic [GAP_W-1:0] gap;
        logic [2:0]       order;
        logic [CH_W-1:0]  scale;
        logic             four;
        logic             solid;
        logic [PX_W-1:0]  color;
        logic             err;
        logic             done;
    } ctl_t;

    ctl_t q, d;

    logic            load, take, clr;
    logic            stage_en, stage_full, stage_got;
    logic [PX_W-1:0] stage_px, src_px, tx_word;
    logic [CH_W-1:0] scaled [NUM_CH];
    logic            avail, sending, word_end, act;
    logic [PH_W-1:0] bit_phase;

    assign stage_en = ((q.st == ST_FILL) || (q.st == ST_SEND)) &&
                      !q.solid && (q.fetched < q.cnt);

    led_pixel_stage #(.BYTE_W(CH_W), .CHANS(NUM_CH)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .enable    (stage_en),
        .four_byte (q.four),
        .take      (take),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .full      (stage_full),
        .pixel     (stage_px),
        .got       (stage_got)
    );

    assign src_px = q.solid ? q.color : stage_px;
    assign avail  = q.solid || stage_full;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_scale
        led_chan_scale #(.W(CH_W)) u_scale (
            .val   (src_px[(NUM_CH-1-i)*CH_W +: CH_W]),
            .scale (q.scale),
            .res   (scaled[i])
        );
    end

    assign tx_word = arrange(q.order, scaled[0], scaled[1], scaled[2]);
    assign sending = (q.st == ST_SEND);

    led_bit_serial #(.WORD_W(PX_W), .T1(T1_CYC), .T2(T2_CYC), .T3(T3_CYC)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .word     (tx_word),
        .run      (sending),
        .active   (act),
        .word_end (word_end),
        .phase    (bit_phase)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        load   = 1'b0;
        take   = 1'b0;
        clr    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cnt     = pixel_count;
                    d.sent    = '0;
                    d.fetched = '0;
                    d.gap     = '0;
                    d.order   = cfg_order;
                    d.scale   = cfg_scale;
                    d.four    = cfg_four_byte;
                    d.solid   = cfg_solid;
                    d.color   = solid_color;
                    d.err     = 1'b0;
                    clr       = 1'b1;
                    d.st      = (pixel_count == '0) ? ST_GAP : ST_FILL;
                end
            end
            ST_FILL: begin
                if (avail) begin
                    load   = 1'b1;
                    take   = !q.solid;
                    d.sent = q.sent + 1'b1;
                    d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (word_end) begin
                    if (q.sent == q.cnt) begin
                        d.st  = ST_GAP;
                        d.gap = '0;
                    end else if (avail) begin
                        load   = 1'b1;
                        take   = !q.solid;
                        d.sent = q.sent + 1'b1;
                    end else begin
                        d.err = 1'b1;
                        d.st  = ST_GAP;
                        d.gap = '0;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap == GAP_W'(GAP_CYC)) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (stage_got) begin
            d.fetched = q.fetched + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign led_out  = act ^ cfg_invert;
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign underrun = q.err;
endmodule

// File: rtl/led_wave_encoder_chk.sv
module led_wave_encoder_chk #(
    parameter int PH_W = 8,
    parameter int T12  = 100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            underrun,
    input logic            in_ready,
    input logic            led_out,
    input logic            cfg_invert,
    input logic            sending,
    input logic [PH_W-1:0] phase
);
    AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && (phase >= PH_W'(T12))) |=> !(led_out ^ cfg_invert)); // R1

    AST_FREE_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (led_out == cfg_invert)); // R5

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> busy); // R9

    AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy); // R10
endmodule

bind led_wave_encoder led_wave_encoder_chk #(
    .PH_W (PH_W),
    .T12  (T1_CYC + T2_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .underrun   (underrun),
    .in_ready   (in_ready),
    .led_out    (led_out),
    .cfg_invert (cfg_invert),
    .sending    (sending),
    .phase      (bit_phase)
);

// File: tb/tb_led_wave_encoder.sv
module tb_led_wave_encoder;
    localparam int T1 = 2, T2 = 3, T3 = 2, GAP = 20, CW = 8;
    localparam int TB = T1 + T2 + T3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [CW-1:0] pixel_count = '0;
    logic [2:0] cfg_order = '0;
    logic [7:0] cfg_scale = 8'd255;
    logic cfg_invert = 1'b0, cfg_four_byte = 1'b0, cfg_solid = 1'b0;
    logic [23:0] solid_color = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, led_out, busy, done, underrun;

    int tests = 0, fails = 0;
    int feed[$];
    int expq[$];
    bit take_pend = 1'b0;

    always #4 clk = ~clk;

    led_wave_encoder #(.T1_CYC(T1), .T2_CYC(T2), .T3_CYC(T3), .GAP_CYC(GAP), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pixel_count(pixel_count),
        .cfg_order(cfg_order), .cfg_scale(cfg_scale), .cfg_invert(cfg_invert),
        .cfg_four_byte(cfg_four_byte), .cfg_solid(cfg_solid), .solid_color(solid_color),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .led_out(led_out), .busy(busy), .done(done), .underrun(underrun));

    task automatic chk(input string req, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Byte feeder: the handshake decided before an edge is retired at the next falling edge.
    always @(negedge clk) begin
        if (take_pend) void'(feed.pop_front());
        in_valid = (feed.size() > 0);
        in_data  = (feed.size() > 0) ? 8'(feed[0]) : 8'h00;
        #1 take_pend = in_valid && in_ready;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic int pbyte(int p, int c);
        if (p == 0 && c == 0) return 255;
        return ((p * 53 + c * 97 + 29) * 7) & 255;
    endfunction

    // Model: bit levels for one pixel, channel picks per order code.
    task automatic push_pixel(input int r, input int g, input int b, input int sc,
                              input int ord, input bit inv);
        int ch[3];
        int pick[6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
        int o;
        ch[0] = (r * sc) / 256;
        ch[1] = (g * sc) / 256;
        ch[2] = (b * sc) / 256;
        o = (ord > 5) ? 0 : ord;
        for (int k = 0; k < 3; k++) begin
            int v;
            v = ch[pick[o][k]];
            for (int bt = 7; bt >= 0; bt--) begin
                bit one;
                one = v[bt];
                for (int p = 0; p < TB; p++) begin
                    bit a;
                    a = (p < T1) || (one && (p < T1 + T2));
                    expq.push_back(int'(a ^ inv));
                end
            end
        end
    endtask

    task automatic run_frame(input string req, input int n, input int feed_px, input int sc,
                             input int ord, input bit inv, input bit four, input bit solid,
                             input logic [23:0] color, input bit poke);
        int nsent, mism, pre_cnt, pre_bad, gapc, ready_bad, cyc, stg, trk;
        bit exp_err, done_fall, err_fall;
        cfg_scale = 8'(sc); cfg_order = 3'(ord); cfg_invert = inv;
        cfg_four_byte = four; cfg_solid = solid; solid_color = color;
        expq.delete();
        nsent = solid ? n : ((feed_px < n) ? feed_px : n);
        for (int p = 0; p < nsent; p++) begin
            if (solid) push_pixel(color[23:16], color[15:8], color[7:0], sc, ord, inv);
            else       push_pixel(pbyte(p,0), pbyte(p,1), pbyte(p,2), sc, ord, inv);
        end
        exp_err = !solid && (n > 0) && (feed_px < n);
        @(negedge clk);
        if (!solid) begin
            for (int p = 0; p < feed_px; p++) begin
                if (four) feed.push_back(8'h3C ^ p);
                for (int c = 0; c < 3; c++) feed.push_back(pbyte(p, c));
            end
        end
        start = 1'b1; pixel_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
        #2;
        mism = 0; pre_cnt = 0; pre_bad = 0; gapc = 0; ready_bad = 0; cyc = 0;
        stg = 0; trk = 0; done_fall = 0; err_fall = 0;
        forever begin
            cyc++;
            if (cyc > 20000) begin
                chk(req, 0, 1, "frame never ended");
                break;
            end
            if (solid && in_ready) ready_bad++;
            if (stg == 0) begin
                if (!busy) begin
                    done_fall = done; err_fall = underrun;
                    break;
                end else if (led_out == !inv) begin
                    stg = 1;
                end else begin
                    pre_cnt++;
                end
            end
            if (stg == 1) begin
                if (expq.size() == 0) stg = 2;
                else begin
                    int e;
                    e = expq.pop_front();
                    trk++;
                    if (int'(led_out) != e) begin
                        if (mism == 0) $display("  mismatch %s at bit cycle %0d: line %0d model %0d", req, trk, led_out, e);
                        mism++;
                    end
                end
                if (poke) start = (trk == 30);
            end
            if (stg == 2) begin
                if (busy) begin
                    gapc++;
                    if (led_out != inv) mism++;
                end else begin
                    done_fall = done; err_fall = underrun;
                    break;
                end
            end
            @(negedge clk);
            #2;
        end
        start = 1'b0;
        chk(req, mism, 0, "waveform mismatches vs model");
        if (nsent > 0) begin
            chk("R12", (stg > 0) && (pre_cnt < 40), 1, "idle lead-in before first bit");
            chk("R6", gapc, GAP, "idle busy cycles after last bit");
        end else begin
            chk("R11", pre_cnt, GAP + 1, "busy cycles of empty frame");
        end
        chk("R6", done_fall, 1, "done at busy fall");
        chk("R9", err_fall, exp_err, "underrun flag");
        if (solid) chk("R8", ready_bad, 0, "in_ready cycles in solid frame");
        chk(req, feed.size(), 0, "input bytes left unconsumed");
        @(negedge clk); #2;
        chk("R6", done, 0, "done one cycle only");
        feed.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #2;
        chk("R10", busy, 0, "busy after reset");
        chk("R10", done, 0, "done after reset");
        chk("R10", in_ready, 0, "in_ready after reset");
        chk("R10", underrun, 0, "underrun after reset");
        chk("R10", led_out, 0, "line after reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk("R10", busy, 0, "busy idle after reset release");
        chk("R5", led_out, 0, "idle line with invert low");

        run_frame("R1", 3, 3, 255, 0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        run_frame("R2", 4, 4, 200, 1, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        run_frame("R3", 3, 3, 128, 2, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        run_frame("R3", 2, 2, 255, 4, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        run_frame("R3", 2, 2, 255, 7, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        run_frame("R4", 2, 2, 0, 0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        run_frame("R4", 2, 2, 77, 3, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        cfg_invert = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk("R5", led_out, 1, "idle line with invert high");
        run_frame("R5", 2, 2, 255, 5, 1'b1, 1'b0, 1'b0, 24'h0, 1'b0);
        run_frame("R7", 3, 3, 255, 0, 1'b0, 1'b1, 1'b0, 24'h0, 1'b0);
        run_frame("R8", 4, 0, 255, 2, 1'b0, 1'b0, 1'b1, 24'hC3_5A_0F, 1'b0);
        run_frame("R9", 3, 1, 255, 0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        chk("R9", underrun, 1, "underrun held after frame");
        run_frame("R11", 0, 0, 255, 0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
        chk("R9", underrun, 0, "underrun cleared by next start");
        run_frame("R11", 3, 3, 255, 1, 1'b0, 1'b0, 1'b0, 24'h0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule